// File: doc/BRIEF.md
# SDRAM Mode Register Set Sequencer

This block sits on the bus side of a memory controller. It turns one CPU byte write into a four-kilobyte address window into the command sequence that loads an SDRAM mode register. The value to load comes from the low twelve bits of the write address, not from write data. For this reason the CPU port has no data lines. One window serves the SDRAM on chip-select area 2 and a second window serves area 3.

When a request is accepted, the block first issues a precharge-all-banks command. After a programmable recovery gap it issues the mode-register-set command, with the SDRAM address pins carrying the re-aligned offset. A second programmable gap follows, and then the CPU is released with a one-cycle ready pulse. Re-alignment depends on the data bus width. On a 32-bit bus, CPU address bit 2 meets SDRAM A0, so the offset is shifted right by two. On a 16-bit bus, CPU address bit 1 meets A0, so the shift is one. Writes that miss both windows, or that are not byte sized, are acknowledged without any SDRAM command.

Top module: `sdram_mrs_seq`

## Requirements
- R1: After reset `cpu_ready` is low, both `sd_cs_n` bits are high and `sd_ras_n`, `sd_cas_n`, `sd_we_n` are all high (no-operation).
- R2: A request addressed within 0xFFFFD000–0xFFFFDFFF selects area 2 and drives only `sd_cs_n[0]` low. A request within 0xFFFFE000–0xFFFFEFFF selects area 3 and drives only `sd_cs_n[1]` low. The selected line is low during both commands of the sequence.
- R3: Only `cpu_size` = 2'b00 (byte) starts a sequence. Sizes 2'b01 (16-bit) and 2'b10 (32-bit) to a window issue no SDRAM command and raise `cpu_ready` in the first cycle after acceptance.
- R4: A write outside both windows issues no SDRAM command and raises `cpu_ready` in the first cycle after acceptance.
- R5: Precharge-all is RAS low, CAS high, WE low, with `sd_addr` bit `PALL_BIT` (default 10) high and all other `sd_addr` bits low. Mode-register-set is RAS, CAS and WE all low.
- R6: Precharge-all appears in the first cycle after acceptance. Mode-register-set appears exactly `TRP_CYC`+1 cycles after precharge-all, and the cycles between carry no command. Both gaps must be at least 1.
- R7: `cpu_ready` is high for exactly one cycle, `TMRD_CYC`+1 cycles after mode-register-set. It stays low from acceptance until then.
- R8: When `bus16` = 0, `sd_addr` during mode-register-set equals address offset bits [11:2]. For example, offsets 0x840, 0x880 and 0x8C0 give bit 9 set and latency field `sd_addr[6:4]` = 1, 2 and 3.
- R9: When `bus16` = 1, `sd_addr` during mode-register-set equals address offset bits [11:1]. For example, offsets 0x420, 0x440 and 0x460 give the same pin values as in R8.
- R10: `bus16` is sampled in the accepting cycle. Changing it later in the sequence does not alter the mode value driven.
- R11: Outside the two command cycles, both chip selects are high and the command pins carry no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 32 | CPU write address |
| cpu_size | input | 2 | Access size: 00 byte, 01 16-bit, 10 32-bit |
| cpu_wr | input | 1 | Write strobe, held until the ready cycle |
| bus16 | input | 1 | 1 selects 16-bit bus mapping, 0 selects 32-bit |
| cpu_ready | output | 1 | One-cycle completion pulse |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | SD_AW | SDRAM address pins |

## Verification
The bench records every command cycle of a sequence and checks the precise cycle of each command and of ready. An off-by-one in either gap counter therefore shows up as a moved command, not as a hang. All three latencies are driven at both bus widths into both areas. A shift picked for the wrong width would place the latency field one bit away, and a swapped area decode would pull down the wrong chip select. Halfword and longword writes to a window, and a write just past a window, are each expected to return ready with silent pins; a design that ignores size or bound would precharge a device. `bus16` is flipped mid-sequence, which catches a design that reads the width when it drives the mode command instead of at acceptance.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PALL,
        ST_TRP,
        ST_MRS,
        ST_TMRD,
        ST_RESP
    } mrs_state_e;

    // RAS, CAS, WE (active low)
    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_PALL = 3'b010;
    localparam logic [2:0] CMD_MRS  = 3'b000;

    localparam logic [1:0] SIZE_BYTE = 2'b00;

endpackage

// File: rtl/mrs_win_decode.sv
module mrs_win_decode #(
    parameter int          WIN_BITS = 12,
    parameter logic [31:0] BASE_A2  = 32'hFFFF_D000,
    parameter logic [31:0] BASE_A3  = 32'hFFFF_E000
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    output logic        start_ok,
    output logic        area_sel
);
    import sdram_mrs_pkg::*;

    logic in_a2;
    logic in_a3;

    always_comb begin
        in_a2    = (addr[31:WIN_BITS] == BASE_A2[31:WIN_BITS]);
        in_a3    = (addr[31:WIN_BITS] == BASE_A3[31:WIN_BITS]);
        area_sel = in_a3;
        start_ok = (in_a2 || in_a3) && (size == SIZE_BYTE);
    end

endmodule

// File: rtl/mrs_addr_align.sv
module mrs_addr_align #(
    parameter int WIN_BITS = 12,
    parameter int SD_AW    = 13
) (
    input  logic [WIN_BITS-1:0] offset,
    input  logic                bus16,
    output logic [SD_AW-1:0]    dev_addr
);
    logic [WIN_BITS-1:0] shifted;

    always_comb begin
        if (bus16) shifted = offset >> 1;
        else       shifted = offset >> 2;
    end

    generate
        if (SD_AW > WIN_BITS) begin : g_pad
            assign dev_addr = {{(SD_AW-WIN_BITS){1'b0}}, shifted};
        end else if (SD_AW == WIN_BITS) begin : g_same
            assign dev_addr = shifted;
        end else begin : g_cut
            assign dev_addr = shifted[SD_AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/mrs_seq_fsm.sv
module mrs_seq_fsm #(
    parameter int SD_AW    = 13,
    parameter int PALL_BIT = 10,
    parameter int TRP_CYC  = 2,
    parameter int TMRD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             start_ok,
    input  logic             area_sel,
    input  logic [SD_AW-1:0] dev_addr,
    output logic             ready,
    output logic [1:0]       cs_n,
    output logic [2:0]       cmd,
    output logic [SD_AW-1:0] addr
);
    import sdram_mrs_pkg::*;

    localparam int GAP_MAX = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
    localparam int CW      = $clog2(GAP_MAX + 1);
    localparam logic [SD_AW-1:0] PALL_MASK = SD_AW'(1) << PALL_BIT;

    typedef struct packed {
        mrs_state_e       st;
        logic [CW-1:0]    cnt;
        logic             area;
        logic [SD_AW-1:0] mode;
        logic             ready;
        logic [1:0]       cs_n;
        logic [2:0]       cmd;
        logic [SD_AW-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic logic [1:0] cs_for(input logic a3);
        return a3 ? 2'b01 : 2'b10;
    endfunction

    always_comb begin
        seq_d       = seq_q;
        seq_d.ready = 1'b0;
        seq_d.cs_n  = 2'b11;
        seq_d.cmd   = CMD_NOP;
        seq_d.addr  = '0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req) begin
                    if (start_ok) begin
                        seq_d.st   = ST_PALL;
                        seq_d.area = area_sel;
                        seq_d.mode = dev_addr;
                        seq_d.cs_n = cs_for(area_sel);
                        seq_d.cmd  = CMD_PALL;
                        seq_d.addr = PALL_MASK;
                    end else begin
                        seq_d.st    = ST_RESP;
                        seq_d.ready = 1'b1;
                    end
                end
            end
            ST_PALL: begin
                seq_d.st  = ST_TRP;
                seq_d.cnt = CW'(TRP_CYC - 1);
            end
            ST_TRP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = ST_MRS;
                    seq_d.cs_n = cs_for(seq_q.area);
                    seq_d.cmd  = CMD_MRS;
                    seq_d.addr = seq_q.mode;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_MRS: begin
                seq_d.st  = ST_TMRD;
                seq_d.cnt = CW'(TMRD_CYC - 1);
            end
            ST_TMRD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st    = ST_RESP;
                    seq_d.ready = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_RESP: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= ST_IDLE;
            seq_q.cs_n  <= 2'b11;
            seq_q.cmd   <= CMD_NOP;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready = seq_q.ready;
    assign cs_n  = seq_q.cs_n;
    assign cmd   = seq_q.cmd;
    assign addr  = seq_q.addr;

    assert_cs_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_cmd_has_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> ($countones(~cs_n) == 1));

    assert_nop_no_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) |-> (cs_n == 2'b11));

    assert_pall_bank_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PALL) |-> (addr == PALL_MASK));

    assert_cmd_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    assert_mrs_keeps_area_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (cs_n == cs_for(seq_q.area)));

    assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cmd == CMD_NOP && cs_n == 2'b11));

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq #(
    parameter int          SD_AW    = 13,
    parameter int          PALL_BIT = 10,
    parameter int          TRP_CYC  = 2,
    parameter int          TMRD_CYC = 2,
    parameter int          WIN_BITS = 12,
    parameter logic [31:0] BASE_A2  = 32'hFFFF_D000,
    parameter logic [31:0] BASE_A3  = 32'hFFFF_E000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      cpu_addr,
    input  logic [1:0]       cpu_size,
    input  logic             cpu_wr,
    input  logic             bus16,
    output logic             cpu_ready,
    output logic [1:0]       sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [SD_AW-1:0] sd_addr
);
    logic             start_ok;
    logic             area_sel;
    logic [SD_AW-1:0] dev_addr;
    logic [2:0]       cmd;

    mrs_win_decode #(
        .WIN_BITS (WIN_BITS),
        .BASE_A2  (BASE_A2),
        .BASE_A3  (BASE_A3)
    ) u_dec (
        .addr     (cpu_addr),
        .size     (cpu_size),
        .start_ok (start_ok),
        .area_sel (area_sel)
    );

    mrs_addr_align #(
        .WIN_BITS (WIN_BITS),
        .SD_AW    (SD_AW)
    ) u_align (
        .offset   (cpu_addr[WIN_BITS-1:0]),
        .bus16    (bus16),
        .dev_addr (dev_addr)
    );

    mrs_seq_fsm #(
        .SD_AW    (SD_AW),
        .PALL_BIT (PALL_BIT),
        .TRP_CYC  (TRP_CYC),
        .TMRD_CYC (TMRD_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cpu_wr),
        .start_ok (start_ok),
        .area_sel (area_sel),
        .dev_addr (dev_addr),
        .ready    (cpu_ready),
        .cs_n     (sd_cs_n),
        .cmd      (cmd),
        .addr     (sd_addr)
    );

    assign sd_ras_n = cmd[2];
    assign sd_cas_n = cmd[1];
    assign sd_we_n  = cmd[0];

endmodule

// File: tb/sdram_mrs_seq_test.sv
`timescale 1ns/1ps
module sdram_mrs_seq_test;

    localparam int SD_AW = 13;
    localparam int TRP   = 2;
    localparam int TMRD  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      cpu_addr = '0;
    logic [1:0]       cpu_size = 2'b00;
    logic             cpu_wr = 1'b0;
    logic             bus16 = 1'b0;
    logic             cpu_ready;
    logic [1:0]       sd_cs_n;
    logic             sd_ras_n, sd_cas_n, sd_we_n;
    logic [SD_AW-1:0] sd_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sdram_mrs_seq #(.SD_AW(SD_AW), .TRP_CYC(TRP), .TMRD_CYC(TMRD)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wr(cpu_wr), .bus16(bus16), .cpu_ready(cpu_ready), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Observed trace of one transaction
    int pall_cyc, mrs_cyc, rdy_cyc, cmd_cnt, stray;
    logic [1:0]       pall_cs, mrs_cs;
    logic [SD_AW-1:0] pall_a, mrs_a;

    task automatic run_req(input logic [31:0] a, input logic [1:0] sz,
                           input logic w16, input int flip_at);
        pall_cyc = -1; mrs_cyc = -1; rdy_cyc = -1; cmd_cnt = 0; stray = 0;
        @(negedge clk);
        cpu_addr = a; cpu_size = sz; bus16 = w16; cpu_wr = 1'b1;
        for (int c = 1; c < 40; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == flip_at) bus16 = ~bus16;
            if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b010) begin
                pall_cyc = c; pall_cs = sd_cs_n; pall_a = sd_addr; cmd_cnt++;
            end else if ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b000) begin
                mrs_cyc = c; mrs_cs = sd_cs_n; mrs_a = sd_addr; cmd_cnt++;
            end else if ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) begin
                cmd_cnt++;
            end else if (sd_cs_n != 2'b11) begin
                stray++;
            end
            if (cpu_ready) begin
                rdy_cyc = c;
                @(posedge clk);
                @(negedge clk);
                cpu_wr = 1'b0;
                check(!cpu_ready, "R7", "ready second cycle", cpu_ready, 0);
                break;
            end
        end
    endtask

    task automatic t_reset;
        check(cpu_ready == 1'b0, "R1", "reset ready", cpu_ready, 0);
        check(sd_cs_n == 2'b11, "R1", "reset cs_n", sd_cs_n, 3);
        check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "reset cmd",
              {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    endtask

    task automatic t_mrs(input logic [31:0] a, input logic w16, input int flip_at,
                         input logic area3, input int lat);
        logic [11:0]      off;
        logic [SD_AW-1:0] exp_a;
        logic [1:0]       exp_cs;
        off    = a[11:0];
        // R8/R9/R10: mapping picked by the width present at acceptance
        exp_a  = w16 ? SD_AW'(off >> 1) : SD_AW'(off >> 2);
        exp_cs = area3 ? 2'b01 : 2'b10;
        run_req(a, 2'b00, w16, flip_at);
        check(pall_cyc == 1, "R6", "precharge cycle", pall_cyc, 1);
        check(mrs_cyc == TRP + 2, "R6", "mode-set cycle", mrs_cyc, TRP + 2);
        check(cmd_cnt == 2, "R6", "command count", cmd_cnt, 2);
        check(stray == 0, "R11", "chip select without command", stray, 0);
        check(rdy_cyc == TRP + TMRD + 3, "R7", "ready cycle", rdy_cyc, TRP + TMRD + 3);
        check(pall_cs == exp_cs, "R2", "precharge cs_n", pall_cs, exp_cs);
        check(mrs_cs == exp_cs, "R2", "mode-set cs_n", mrs_cs, exp_cs);
        check(pall_a == SD_AW'(1 << 10), "R5", "precharge address", pall_a, 1 << 10);
        if (w16 && flip_at < 0)
            check(mrs_a == exp_a, "R9", "16-bit mode value", mrs_a, exp_a);
        else if (flip_at < 0)
            check(mrs_a == exp_a, "R8", "32-bit mode value", mrs_a, exp_a);
        else
            check(mrs_a == exp_a, "R10", "width held from start", mrs_a, exp_a);
        if (lat > 0) begin
            check(mrs_a[6:4] == 3'(lat), w16 ? "R9" : "R8", "latency field", mrs_a[6:4], lat);
            check(mrs_a[9] == 1'b1, w16 ? "R9" : "R8", "single-write bit", mrs_a[9], 1);
        end
    endtask

    task automatic t_ignored(input logic [31:0] a, input logic [1:0] sz, input string req);
        run_req(a, sz, 1'b0, -1);
        check(cmd_cnt == 0, req, "commands issued", cmd_cnt, 0);
        check(stray == 0, req, "chip select driven", stray, 0);
        check(rdy_cyc == 1, req, "ready cycle", rdy_cyc, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        // 32-bit bus, both areas, all latencies (R8, R2)
        t_mrs(32'hFFFF_D840, 1'b0, -1, 1'b0, 1);
        t_mrs(32'hFFFF_D880, 1'b0, -1, 1'b0, 2);
        t_mrs(32'hFFFF_E8C0, 1'b0, -1, 1'b1, 3);
        // 16-bit bus (R9)
        t_mrs(32'hFFFF_E420, 1'b1, -1, 1'b1, 1);
        t_mrs(32'hFFFF_D440, 1'b1, -1, 1'b0, 2);
        t_mrs(32'hFFFF_E460, 1'b1, -1, 1'b1, 3);
        // arbitrary offset at window top
        t_mrs(32'hFFFF_DFFF, 1'b0, -1, 1'b0, 0);
        // width flipped mid-sequence (R10)
        t_mrs(32'hFFFF_D880, 1'b0, 2, 1'b0, 2);
        t_mrs(32'hFFFF_E440, 1'b1, 3, 1'b1, 2);
        // non-byte sizes to a window (R3)
        t_ignored(32'hFFFF_D840, 2'b01, "R3");
        t_ignored(32'hFFFF_E880, 2'b10, "R3");
        // outside both windows (R4)
        t_ignored(32'hFFFF_F840, 2'b00, "R4");
        t_ignored(32'hFFFF_C840, 2'b00, "R4");
        t_ignored(32'h0000_D840, 2'b00, "R4");
        // still works after ignored writes
        t_mrs(32'hFFFF_D8C0, 1'b0, -1, 1'b0, 3);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule